// File: doc/BRIEF.md
# Match-Compare System Timer with Clock-Crossing Access Handshakes

This block is a system timer that lives across two clocks. A 32-bit up-counter runs in a timer clock domain. In the target system that tick is 3 MHz. A match register sits beside the counter, and when the enabled counter reaches the match value a sticky status flag is raised in the bus domain. The flag can drive an interrupt output through a one-bit mask.

Software reaches the block through a simple register bus in the bus clock domain. Reading the live count, writing the match value and loading the counter are not direct accesses. Each one is carried across the clock boundary by a two-flop synchronised toggle handshake. An access-status register shows a busy bit for each transfer that is still in flight, and software polls that bit before it starts the next transfer of the same kind.

The request side follows valid/ready rules. `req_ready` is always high, so every request with `req_valid` set is taken on that clock edge. A read returns `rsp_valid` with `rsp_rdata` exactly one cycle after it is accepted. The requester cannot stall a response.

Top module: `sys_match_timer`

## Requirements
- R1: After reset, the register reads are: match value 0xFFFFFFFF, count snapshot 0, status 0, interrupt enable 0, control 0 and access status 0. `irq` is low.
- R2: Every accepted read is followed one cycle later by `rsp_valid` high. No other cycle has `rsp_valid` high. A read of an unmapped offset returns 0, and a write to an unmapped offset changes no register.
- R3: Bit 0 of control (offset 0x20) is the count enable. While it is 0 the counter holds its value. While it is 1 the counter advances by one on every timer clock.
- R4: A control write with bit 1 set starts a snapshot; bit 1 itself is not stored. Access-status bit 5 (offset 0x24) stays high until the live count has landed in the count register (offset 0x10). That register then holds its value until the next snapshot completes.
- R5: A write to offset 0x00 updates the match value that reads back at 0x00 and starts a transfer into the timer domain. Access-status bit 0 stays high while that transfer is in flight. A match write that arrives while bit 0 is high is dropped.
- R6: A write to offset 0x10 loads the counter through the same kind of handshake. Access-status bit 4 marks this transfer as pending. A count write that arrives while bit 4 is high is dropped.
- R7: The counter wraps from 0xFFFFFFFF to 0.
- R8: Status bit 0 (offset 0x14) is set when the enabled counter equals the match value. It stays set until software clears it. A disabled counter that happens to equal the match value does not set it.
- R9: Writing 1 to status bit 0 clears it, and writing 0 to that bit leaves it unchanged. Status bits 3 to 1 always read 0.
- R10: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 (offset 0x1C) are both set.
- R11: If a match event and a clear of status bit 0 arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tmr_clk | input | 1 | Timer tick clock |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted; always high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Masked match interrupt |

## Verification
The assertions assume that `req_addr` and `req_write` are defined whenever `req_valid` is high. They also assume that the two clocks are unrelated, so the handshake latencies are counted in cycles but not fixed. The stimulus drives requests only on falling bus-clock edges and holds each request for exactly one cycle. Between steps it waits for the relevant busy bit to clear by polling the access-status register, except where it deliberately issues a second transfer while the first is still busy. Counter values are checked exactly only while counting is disabled. While counting is enabled, checks compare snapshots by their modular distance from the loaded start value.

// File: rtl/smt_pkg.sv
package smt_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_MATCH  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_ACCESS = 6'h24;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_SNAP_BIT = 1;
  localparam int unsigned ACC_MATCH_BIT = 0;
  localparam int unsigned ACC_CNTW_BIT  = 4;
  localparam int unsigned ACC_SNAP_BIT  = 5;
  localparam int unsigned STATUS_FLAGS  = 4;

  typedef struct packed {
    logic match_busy;
    logic cntw_busy;
    logic snap_busy;
  } acc_flags_t;
endpackage

// File: rtl/smt_sync2.sv
module smt_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/smt_push_xfer.sv
// Carries one data word from the source clock to the destination clock
// with a toggle request and a toggle acknowledge.
module smt_push_xfer #(
  parameter int unsigned W = 32
) (
  input  logic         rst_n,
  input  logic         s_clk,
  input  logic         s_load,
  input  logic [W-1:0] s_data,
  output logic         s_busy,
  input  logic         d_clk,
  output logic         d_pulse,
  output logic [W-1:0] d_data
);
  logic         req_tog;
  logic [W-1:0] hold_q;
  logic         ack_sync;
  logic         req_sync;
  logic         req_seen;

  assign s_busy = req_tog ^ ack_sync;

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog <= 1'b0;
      hold_q  <= '0;
    end else if (s_load && !s_busy) begin
      req_tog <= ~req_tog;
      hold_q  <= s_data;
    end
  end

  smt_sync2 #(.W(1)) u_req_sync (
    .clk (d_clk), .rst_n (rst_n), .d (req_tog), .q (req_sync)
  );

  always_ff @(posedge d_clk or negedge rst_n) begin
    if (!rst_n) req_seen <= 1'b0;
    else        req_seen <= req_sync;
  end

  assign d_pulse = req_sync ^ req_seen;
  assign d_data  = hold_q;

  smt_sync2 #(.W(1)) u_ack_sync (
    .clk (s_clk), .rst_n (rst_n), .d (req_seen), .q (ack_sync)
  );
endmodule

// File: rtl/smt_snap_xfer.sv
// Requests a sample of a destination-domain value and returns it to the
// requesting clock, where it is held until the next sample completes.
module smt_snap_xfer #(
  parameter int unsigned W = 32
) (
  input  logic         rst_n,
  input  logic         s_clk,
  input  logic         s_req,
  output logic         s_busy,
  output logic [W-1:0] s_value,
  input  logic         d_clk,
  input  logic [W-1:0] d_value
);
  logic         req_tog;
  logic         done_seen;
  logic         ack_sync;
  logic         req_sync;
  logic         req_seen;
  logic [W-1:0] snap_q;

  assign s_busy = req_tog ^ done_seen;

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tog   <= 1'b0;
      done_seen <= 1'b0;
      s_value   <= '0;
    end else begin
      if (s_req && !s_busy) req_tog <= ~req_tog;
      if (ack_sync ^ done_seen) begin
        done_seen <= ack_sync;
        s_value   <= snap_q;
      end
    end
  end

  smt_sync2 #(.W(1)) u_req_sync (
    .clk (d_clk), .rst_n (rst_n), .d (req_tog), .q (req_sync)
  );

  always_ff @(posedge d_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      snap_q   <= '0;
    end else if (req_sync ^ req_seen) begin
      req_seen <= req_sync;
      snap_q   <= d_value;
    end
  end

  smt_sync2 #(.W(1)) u_ack_sync (
    .clk (s_clk), .rst_n (rst_n), .d (req_seen), .q (ack_sync)
  );
endmodule

// File: rtl/smt_pulse_xfer.sv
// Moves single-cycle events from one clock to another through a toggle.
module smt_pulse_xfer (
  input  logic rst_n,
  input  logic s_clk,
  input  logic s_pulse,
  input  logic d_clk,
  output logic d_pulse
);
  logic ev_tog;
  logic ev_sync;
  logic ev_seen;

  always_ff @(posedge s_clk or negedge rst_n) begin
    if (!rst_n)       ev_tog <= 1'b0;
    else if (s_pulse) ev_tog <= ~ev_tog;
  end

  smt_sync2 #(.W(1)) u_ev_sync (
    .clk (d_clk), .rst_n (rst_n), .d (ev_tog), .q (ev_sync)
  );

  always_ff @(posedge d_clk or negedge rst_n) begin
    if (!rst_n) ev_seen <= 1'b0;
    else        ev_seen <= ev_sync;
  end

  assign d_pulse = ev_sync ^ ev_seen;
endmodule

// File: rtl/smt_timer_core.sv
// Timer-domain counter and match comparator.
module smt_timer_core #(
  parameter int unsigned W = 32
) (
  input  logic         tmr_clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld_pulse,
  input  logic [W-1:0] ld_value,
  input  logic         mt_pulse,
  input  logic [W-1:0] mt_value,
  output logic [W-1:0] count,
  output logic         hit
);
  logic [W-1:0] count_q;
  logic [W-1:0] match_q;

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (ld_pulse) count_q <= ld_value;
    else if (run)      count_q <= count_q + 1'b1;
  end

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n)        match_q <= '1;
    else if (mt_pulse) match_q <= mt_value;
  end

  assign count = count_q;
  assign hit   = run && (count_q == match_q);
endmodule

// File: rtl/sys_match_timer.sv
module sys_match_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = smt_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_clk,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  import smt_pkg::*;

  localparam int unsigned PAD_W = DATA_W - STATUS_FLAGS;

  logic              wr_acc;
  logic              rd_acc;
  logic              ctrl_en;
  logic              ier_q;
  logic              flag_q;
  logic [DATA_W-1:0] match_shadow;
  logic [DATA_W-1:0] count_rd;
  logic              match_busy;
  logic              cntw_busy;
  logic              snap_busy;
  logic              ev_pulse;
  acc_flags_t        acc;

  logic              run_t;
  logic              ld_pulse_t;
  logic [DATA_W-1:0] ld_value_t;
  logic              mt_pulse_t;
  logic [DATA_W-1:0] mt_value_t;
  logic [DATA_W-1:0] count_t;
  logic              hit_t;

  assign req_ready = 1'b1;
  assign wr_acc    = req_valid && req_write;
  assign rd_acc    = req_valid && !req_write;

  wire wr_match  = wr_acc && (req_addr == OFF_MATCH);
  wire wr_count  = wr_acc && (req_addr == OFF_COUNT);
  wire wr_status = wr_acc && (req_addr == OFF_STATUS);
  wire wr_ien    = wr_acc && (req_addr == OFF_IEN);
  wire wr_ctrl   = wr_acc && (req_addr == OFF_CTRL);

  // Bus-domain register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en      <= 1'b0;
      ier_q        <= 1'b0;
      match_shadow <= '1;
    end else begin
      if (wr_ctrl)                 ctrl_en      <= req_wdata[CTRL_EN_BIT];
      if (wr_ien)                  ier_q        <= req_wdata[0];
      if (wr_match && !match_busy) match_shadow <= req_wdata;
    end
  end

  // Match flag: a new event wins over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flag_q <= 1'b0;
    else if (ev_pulse)                 flag_q <= 1'b1;
    else if (wr_status && req_wdata[0]) flag_q <= 1'b0;
  end

  assign irq = flag_q && ier_q;

  assign acc.match_busy = match_busy;
  assign acc.cntw_busy  = cntw_busy;
  assign acc.snap_busy  = snap_busy;

  // Read response, one cycle after acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) begin
        rsp_rdata <= '0;
        unique case (req_addr)
          OFF_MATCH:  rsp_rdata <= match_shadow;
          OFF_COUNT:  rsp_rdata <= count_rd;
          OFF_STATUS: rsp_rdata <= {{PAD_W{1'b0}}, 3'b000, flag_q};
          OFF_IEN:    rsp_rdata[0] <= ier_q;
          OFF_CTRL:   rsp_rdata[CTRL_EN_BIT] <= ctrl_en;
          OFF_ACCESS: begin
            rsp_rdata[ACC_MATCH_BIT] <= acc.match_busy;
            rsp_rdata[ACC_CNTW_BIT]  <= acc.cntw_busy;
            rsp_rdata[ACC_SNAP_BIT]  <= acc.snap_busy;
          end
          default: rsp_rdata <= '0;
        endcase
      end
    end
  end

  // Clock crossings
  smt_sync2 #(.W(1)) u_run_sync (
    .clk (tmr_clk), .rst_n (rst_n), .d (ctrl_en), .q (run_t)
  );

  smt_push_xfer #(.W(DATA_W)) u_match_xfer (
    .rst_n   (rst_n),
    .s_clk   (clk),
    .s_load  (wr_match),
    .s_data  (req_wdata),
    .s_busy  (match_busy),
    .d_clk   (tmr_clk),
    .d_pulse (mt_pulse_t),
    .d_data  (mt_value_t)
  );

  smt_push_xfer #(.W(DATA_W)) u_count_xfer (
    .rst_n   (rst_n),
    .s_clk   (clk),
    .s_load  (wr_count),
    .s_data  (req_wdata),
    .s_busy  (cntw_busy),
    .d_clk   (tmr_clk),
    .d_pulse (ld_pulse_t),
    .d_data  (ld_value_t)
  );

  smt_snap_xfer #(.W(DATA_W)) u_snap_xfer (
    .rst_n   (rst_n),
    .s_clk   (clk),
    .s_req   (wr_ctrl && req_wdata[CTRL_SNAP_BIT]),
    .s_busy  (snap_busy),
    .s_value (count_rd),
    .d_clk   (tmr_clk),
    .d_value (count_t)
  );

  smt_pulse_xfer u_hit_xfer (
    .rst_n   (rst_n),
    .s_clk   (tmr_clk),
    .s_pulse (hit_t),
    .d_clk   (clk),
    .d_pulse (ev_pulse)
  );

  smt_timer_core #(.W(DATA_W)) u_core (
    .tmr_clk  (tmr_clk),
    .rst_n    (rst_n),
    .run      (run_t),
    .ld_pulse (ld_pulse_t),
    .ld_value (ld_value_t),
    .mt_pulse (mt_pulse_t),
    .mt_value (mt_value_t),
    .count    (count_t),
    .hit      (hit_t)
  );
endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              match_busy,
  input logic [DATA_W-1:0] match_shadow,
  input logic              snap_busy,
  input logic [DATA_W-1:0] count_rd,
  input logic              flag_q,
  input logic              ev_pulse
);
  // R2: a response follows each accepted read, and only those
  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R5: a match write while busy leaves the match value untouched
  p_match_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_busy && req_valid && req_write && req_addr == 6'h00)
      |=> $stable(match_shadow));

  // R4: the snapshot only moves when a transfer completes
  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(snap_busy) |-> $stable(count_rd));

  // R8: the flag stays set unless software clears it
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(req_valid && req_write && req_addr == 6'h14 && req_wdata[0]))
      |=> flag_q);

  // R11: an event always leaves the flag set
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse |=> flag_q);

  // R9: upper status bits read as zero
  p_status_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 6'h14) |=> (rsp_rdata[3:1] == 3'b000));
endmodule

bind sys_match_timer smt_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_smt_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .match_busy   (match_busy),
  .match_shadow (match_shadow),
  .snap_busy    (snap_busy),
  .count_rd     (count_rd),
  .flag_q       (flag_q),
  .ev_pulse     (ev_pulse)
);

// File: tb/sys_match_timer_tb.sv
module sys_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always #15 tmr_clk = ~tmr_clk;

  sys_match_timer dut_i (
    .clk (clk), .rst_n (rst_n), .tmr_clk (tmr_clk),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .irq (irq)
  );

  localparam logic [5:0] A_MATCH = 6'h00, A_COUNT = 6'h10, A_STAT = 6'h14,
                         A_IEN = 6'h1C, A_CTRL = 6'h20, A_ACC = 6'h24;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  logic last_rsp_valid;
  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    last_rsp_valid = rsp_valid;
    d = rsp_rdata;
  endtask

  task automatic wait_idle(input int bitn);
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      bus_rd(A_ACC, v);
      if (!v[bitn]) return;
    end
    check(1'b0, "R4/R5/R6 busy bit never cleared", v, 32'h0);
  endtask

  task automatic snapshot(input bit en, output logic [31:0] d);
    bus_wr(A_CTRL, {30'd0, 1'b1, en});
    wait_idle(5);
    bus_rd(A_COUNT, d);
  endtask

  task automatic load_count(input logic [31:0] c);
    bus_wr(A_COUNT, c);
    wait_idle(4);
  endtask

  task automatic set_match(input logic [31:0] m);
    bus_wr(A_MATCH, m);
    wait_idle(0);
  endtask

  initial begin : watchdog
    #3_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, s1, s2, diff;
    logic [31:0] starts [3];
    int unsigned deltas [5];
    starts = '{32'h0, 32'd1000, 32'hFFFF_FFF0};
    deltas = '{0, 1, 5, 17, 40};

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset values
    check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'h0);
    bus_rd(A_MATCH, v);  check(v == 32'hFFFF_FFFF, "R1 match reset", v, 32'hFFFF_FFFF);
    check(last_rsp_valid, "R2 rsp_valid one cycle after read", {31'd0, last_rsp_valid}, 32'h1);
    bus_rd(A_COUNT, v);  check(v == 32'h0, "R1 count reset", v, 32'h0);
    bus_rd(A_STAT, v);   check(v == 32'h0, "R1 status reset", v, 32'h0);
    bus_rd(A_IEN, v);    check(v == 32'h0, "R1 ien reset", v, 32'h0);
    bus_rd(A_CTRL, v);   check(v == 32'h0, "R1 ctrl reset", v, 32'h0);
    bus_rd(A_ACC, v);    check(v == 32'h0, "R1 access reset", v, 32'h0);
    check(req_ready == 1'b1, "R2 req_ready high", {31'd0, req_ready}, 32'h1);

    // R2: unmapped read/write
    bus_wr(6'h04, 32'hFFFF_FFFF);
    bus_rd(6'h04, v);    check(v == 32'h0, "R2 unmapped read", v, 32'h0);
    bus_rd(A_IEN, v);    check(v == 32'h0, "R2 unmapped write ignored (ien)", v, 32'h0);
    bus_rd(A_CTRL, v);   check(v == 32'h0, "R2 unmapped write ignored (ctrl)", v, 32'h0);

    // R3: disabled counter holds
    repeat (20) @(negedge clk);
    snapshot(1'b0, v);   check(v == 32'h0, "R3 disabled counter holds", v, 32'h0);

    // R6: exact loads while disabled; R4 snapshot value
    foreach (starts[i]) begin
      load_count(starts[i] ^ 32'h5A5A_0000);
      snapshot(1'b0, v);
      check(v == (starts[i] ^ 32'h5A5A_0000), "R6/R4 load then snapshot", v,
            starts[i] ^ 32'h5A5A_0000);
    end

    // R4: busy bit high right after request, snapshot held after completion
    bus_wr(A_CTRL, 32'h2);
    bus_rd(A_ACC, v);    check(v[5] == 1'b1, "R4 snapshot busy bit", v, 32'h20);
    wait_idle(5);
    bus_rd(A_CTRL, v);   check(v == 32'h0, "R4 snapshot bit not stored", v, 32'h0);

    // R6: second count write while busy is dropped
    bus_wr(A_COUNT, 32'd777);
    bus_rd(A_ACC, v);    check(v[4] == 1'b1, "R6 count write busy bit", v, 32'h10);
    bus_wr(A_COUNT, 32'd999);
    wait_idle(4);
    snapshot(1'b0, v);   check(v == 32'd777, "R6 dropped count write", v, 32'd777);

    // R5: second match write while busy is dropped
    bus_wr(A_MATCH, 32'h1234_5678);
    bus_rd(A_ACC, v);    check(v[0] == 1'b1, "R5 match busy bit", v, 32'h1);
    bus_wr(A_MATCH, 32'h0BAD_0BAD);
    wait_idle(0);
    bus_rd(A_MATCH, v);  check(v == 32'h1234_5678, "R5 dropped match write", v, 32'h1234_5678);

    // R3: enabled counter advances
    bus_wr(A_CTRL, 32'h1);
    snapshot(1'b1, s1);
    repeat (30) @(negedge clk);
    snapshot(1'b1, s2);
    check((s2 - s1) >= 32'd20, "R3 counter advances when enabled", s2 - s1, 32'd20);
    bus_wr(A_CTRL, 32'h0);

    // R8/R7: sweep of start values and match distances
    foreach (starts[i]) begin
      foreach (deltas[j]) begin
        bus_wr(A_CTRL, 32'h0);
        load_count(starts[i]);
        set_match(starts[i] + deltas[j]);
        bus_wr(A_STAT, 32'hF);
        repeat (10) @(negedge clk);
        bus_rd(A_STAT, v);
        check(v == 32'h0, "R8 no flag while disabled", v, 32'h0);
        bus_wr(A_CTRL, 32'h1);
        for (int k = 0; k < 200; k++) begin
          bus_rd(A_STAT, v);
          if (v[0]) break;
        end
        check(v == 32'h1, "R8 flag set on match", v, 32'h1);
        bus_wr(A_CTRL, 32'h0);
        snapshot(1'b0, s1);
        diff = s1 - starts[i];
        check(diff >= deltas[j], "R8 flag not before match", diff, deltas[j]);
        if (starts[i] == 32'hFFFF_FFF0 && deltas[j] == 40)
          check(s1 < 32'h100, "R7 counter wrapped", s1, 32'h18);
      end
    end

    // R8: far match not reached
    load_count(32'd10);
    set_match(32'd100000);
    bus_wr(A_STAT, 32'hF);
    bus_wr(A_CTRL, 32'h1);
    repeat (40) @(negedge clk);
    bus_rd(A_STAT, v);   check(v == 32'h0, "R8 no flag before match reached", v, 32'h0);
    bus_wr(A_CTRL, 32'h0);

    // R10/R9: interrupt gating and write-one-to-clear
    load_count(32'd50);
    set_match(32'd52);
    bus_wr(A_CTRL, 32'h1);
    for (int k = 0; k < 100; k++) begin
      bus_rd(A_STAT, v);
      if (v[0]) break;
    end
    bus_wr(A_CTRL, 32'h0);
    repeat (10) @(negedge clk);
    check(irq == 1'b0, "R10 irq masked", {31'd0, irq}, 32'h0);
    bus_wr(A_IEN, 32'h1);
    @(negedge clk);
    check(irq == 1'b1, "R10 irq when enabled and flagged", {31'd0, irq}, 32'h1);
    bus_wr(A_STAT, 32'hE);
    bus_rd(A_STAT, v);   check(v == 32'h1, "R9 writing zero keeps flag", v, 32'h1);
    check(irq == 1'b1, "R10 irq still high", {31'd0, irq}, 32'h1);
    bus_wr(A_STAT, 32'h1);
    bus_rd(A_STAT, v);   check(v == 32'h0, "R9 write one clears", v, 32'h0);
    check(irq == 1'b0, "R10 irq drops after clear", {31'd0, irq}, 32'h0);
    bus_rd(A_IEN, v);    check(v == 32'h1, "R10 ien readback", v, 32'h1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule